// File: doc/BRIEF.md
# Serial Clock Wait and Interrupt Controller

This block is the clock-line control for a serial port that can work in a two-wire bus mode. The CPU sees one 8-bit control/status register. The block watches the serial clock pin and counts its rising edges inside a byte transfer. On a chosen edge it raises a one-cycle interrupt request. In the wait modes it then holds the clock line low, which stretches the clock, until software writes a release bit. The release bit clears itself once the hold ends.

Between transfers, a control bit picks the idle state of the clock line: pulled low, or released so that a master can form start and stop conditions. The register also reports the synchronized level of the clock pin. The clock pin is open-drain and is modelled as a single pull-low enable. Transfer start and end arrive as single-cycle strobes from the surrounding serial logic.

The control is a three-state machine:
- **ST_IDLE**: no transfer in progress.
- **ST_SHIFT**: a transfer is running and edges are being counted.
- **ST_HOLD**: the clock is held low.

Transitions:
- **ST_IDLE → ST_SHIFT** on a start strobe.
- **ST_SHIFT → ST_SHIFT** on a start strobe; the edge count restarts.
- **ST_SHIFT → ST_IDLE** on an end strobe.
- **ST_SHIFT → ST_HOLD** when the trigger edge is counted in a wait mode.
- **ST_HOLD → ST_SHIFT** when the release bit is set.

No other event leaves ST_HOLD.

Top module: `sclk_wait_ctrl`

## Requirements
- R1: After reset:
  - every stored register field reads 0;
  - bus_rdata bit 6 follows the pin;
  - irq is 0;
  - scl_drive_low is 1, because idle with the clock-level bit at 0 pulls the line low.
- R2: With mode field bits[1:0] = 2'b10, irq pulses for one cycle on the 8th counted rising edge. scl_drive_low is 1 from that same cycle until the hold is released.
- R3: With mode 2'b11, no irq occurs on the 8th edge. irq pulses on the 9th edge, followed by the same clock-low hold.
- R4: With mode 2'b00, irq pulses on the 8th edge and no hold is entered, so scl_drive_low stays 0 during the transfer.
- R5: Mode 2'b01 is reserved. It produces no irq and no hold over 9 or more edges.
- R6: Writing 1 to bit 2 (release) during a hold behaves as follows:
  - bit 2 reads 1 in the cycle after the write, while the line is still held;
  - one cycle later, bit 2 reads 0 and scl_drive_low is 0.
- R7: Writing 1 to bit 2 while no hold is active has no effect. Bit 2 reads 0 and scl_drive_low is unchanged.
- R8: Rising edges that arrive during a hold are not counted. After a release in mode 2'b10 followed by a switch to 2'b11, the next edge is the 9th.
- R9: A start strobe during a transfer restarts the edge count from 0.
- R10: When idle, bit 3 = 0 gives scl_drive_low = 1, and bit 3 = 1 gives scl_drive_low = 0. During a transfer outside a hold, scl_drive_low is 0 whatever bit 3 holds.
- R11: The register fields behave as follows:
  - bit 6 reads the pin level after two synchronizer stages, and writes to bit 6 are ignored;
  - bits 7, 5 and 4 read back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| xfer_start | input | 1 | Transfer start strobe |
| xfer_stop | input | 1 | Transfer end strobe |
| scl_in | input | 1 | Clock pin level (asynchronous) |
| scl_drive_low | output | 1 | Pull-low enable for the clock pin |
| irq | output | 1 | One-cycle interrupt request |

## Verification
- A pin rise presented after cycle k passes two synchronizer stages and is counted at the third clock edge. The driver therefore queues the expected interrupt for cycle k+3, and the monitor compares every irq pulse against the head of that queue.
- A register write captured at an edge is visible at the next falling-edge sample.
- The hold begins in the same cycle as the interrupt.
- A release appears on the clock enable one cycle after the release bit is read as 1.
- All outputs are sampled on the falling clock edge, so every check lands on the cycle the design settles to.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_SHIFT = 2'b01,
        ST_HOLD  = 2'b10
    } fsm_t;

    typedef enum logic [1:0] {
        MD_NOWAIT8 = 2'b00,
        MD_RSVD    = 2'b01,
        MD_WAIT8   = 2'b10,
        MD_WAIT9   = 2'b11
    } wmode_t;

endpackage

// File: rtl/sclk_sync.sv
// Pin synchronizer with rising-edge detector.
module sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise
);
    logic [STAGES:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else begin
            sr <= {sr[STAGES-1:0], pin};
        end
    end

    assign level = sr[STAGES-1];
    assign rise  = sr[STAGES-1] & ~sr[STAGES];
endmodule

// File: rtl/sclk_edge_cnt.sv
// Saturating edge counter with synchronous clear.
module sclk_edge_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CMAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && cnt != CMAX) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sclk_ctrl_reg.sv
// Control/status register: stored fields, self-clearing release, live level.
module sclk_ctrl_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       holding,
    input  logic       rel_done,
    input  logic       scl_level,
    output logic [7:0] rd_data,
    output logic [1:0] wat,
    output logic       clc,
    output logic       wrel
);
    logic [2:0] spare;
    logic       unused_cld_wr;

    assign unused_cld_wr = wr_data[6];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spare <= '0;
            clc   <= 1'b0;
            wat   <= 2'b00;
            wrel  <= 1'b0;
        end else begin
            if (wr_en) begin
                spare <= {wr_data[7], wr_data[5], wr_data[4]};
                clc   <= wr_data[3];
                wat   <= wr_data[1:0];
            end
            if (rel_done) begin
                wrel <= 1'b0;
            end else if (wr_en && wr_data[2] && holding) begin
                wrel <= 1'b1;
            end
        end
    end

    assign rd_data = {spare[2], scl_level, spare[1], spare[0], clc, wrel, wat};
endmodule

// File: rtl/sclk_wait_ctrl.sv
// Top: edge-count FSM with interrupt trigger and clock-low hold.
module sclk_wait_ctrl
    import sclk_pkg::*;
#(
    parameter int BITS_PER_BYTE = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       xfer_start,
    input  logic       xfer_stop,
    input  logic       scl_in,
    output logic       scl_drive_low,
    output logic       irq
);
    localparam int CNT_W = $clog2(BITS_PER_BYTE + 2);
    localparam logic [CNT_W-1:0] HIT_FIRST  = CNT_W'(BITS_PER_BYTE - 1);
    localparam logic [CNT_W-1:0] HIT_SECOND = CNT_W'(BITS_PER_BYTE);

    fsm_t             state_q, state_d;
    logic             irq_q, irq_d;
    logic             scl_level, scl_rise;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       wat;
    logic             clc, wrel;
    logic             holding, rel_done;
    logic             cnt_clr, cnt_inc;
    logic             hit8, hit9, fire;
    wmode_t           mode;

    sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (scl_in),
        .level (scl_level),
        .rise  (scl_rise)
    );

    sclk_ctrl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .wr_data   (bus_wdata),
        .holding   (holding),
        .rel_done  (rel_done),
        .scl_level (scl_level),
        .rd_data   (bus_rdata),
        .wat       (wat),
        .clc       (clc),
        .wrel      (wrel)
    );

    sclk_edge_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt_q)
    );

    assign mode    = wmode_t'(wat);
    assign cnt_clr = xfer_start && (state_q != ST_HOLD);
    assign cnt_inc = scl_rise && (state_q == ST_SHIFT) && !xfer_stop;
    assign hit8    = cnt_inc && (cnt_q == HIT_FIRST);
    assign hit9    = cnt_inc && (cnt_q == HIT_SECOND);

    always_comb begin
        fire = 1'b0;
        unique case (mode)
            MD_NOWAIT8: fire = hit8;
            MD_RSVD:    fire = 1'b0;
            MD_WAIT8:   fire = hit8;
            MD_WAIT9:   fire = hit9;
            default:    fire = 1'b0;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d  = state_q;
        irq_d    = 1'b0;
        rel_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (xfer_start) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (xfer_start) begin
                    state_d = ST_SHIFT;
                end else if (xfer_stop) begin
                    state_d = ST_IDLE;
                end else if (fire) begin
                    irq_d = 1'b1;
                    if (wat[1]) state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (wrel) begin
                    state_d  = ST_SHIFT;
                    rel_done = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= irq_d;
        end
    end

    // outputs
    always_comb begin
        holding       = (state_q == ST_HOLD);
        irq           = irq_q;
        scl_drive_low = 1'b0;
        unique case (state_q)
            ST_IDLE:  scl_drive_low = ~clc;
            ST_SHIFT: scl_drive_low = 1'b0;
            ST_HOLD:  scl_drive_low = 1'b1;
            default:  scl_drive_low = 1'b0;
        endcase
    end
endmodule

// File: rtl/sclk_wait_chk.sv
// Property checker, bound into the top module.
module sclk_wait_chk
    import sclk_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             wr_rel_bit,
    input logic             irq,
    input logic             scl_drive_low,
    input fsm_t             st,
    input logic [CNT_W-1:0] cnt,
    input logic [1:0]       wat,
    input logic             wrel
);
    // R2: the interrupt is a single-cycle pulse
    a_r2_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R2 / R3: in a wait mode, the clock is held low in the cycle of the interrupt
    a_r2_wait_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(wat[1])) |-> scl_drive_low);

    // R5: the reserved mode never raises an interrupt
    a_r5_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (wat == 2'b01 && $past(wat) == 2'b01) |-> !irq);

    // R6: the release bit clears itself one cycle after it is set
    a_r6_wrel_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wrel |=> !wrel);

    // R6: the hold stays until the release bit is seen
    a_r6_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && !wrel) |=> scl_drive_low);

    // R7: a release written outside a hold is dropped
    a_r7_wrel_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wr_rel_bit && st != ST_HOLD) |=> !wrel);

    // R8: the edge count is frozen while holding
    a_r8_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |=> $stable(cnt));
endmodule

bind sclk_wait_ctrl sclk_wait_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .wr_rel_bit    (bus_wdata[2]),
    .irq           (irq),
    .scl_drive_low (scl_drive_low),
    .st            (state_q),
    .cnt           (cnt_q),
    .wat           (wat),
    .wrel          (wrel)
);

// File: tb/tb_sclk_wait_ctrl.sv
`timescale 1ns/1ps
module tb_sclk_wait_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       xfer_start = 1'b0;
    logic       xfer_stop = 1'b0;
    logic       scl_in = 1'b0;
    logic       scl_drive_low;
    logic       irq;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";
    int    exp_cyc[$];
    string exp_tag[$];

    sclk_wait_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .xfer_start    (xfer_start),
        .xfer_stop     (xfer_stop),
        .scl_in        (scl_in),
        .scl_drive_low (scl_drive_low),
        .irq           (irq)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_eq(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: every irq pulse must match the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && irq && !finished) begin
            n_chk++;
            if (exp_cyc.size() == 0) begin
                n_fail++;
                $display("FAIL %s unexpected irq actual=%0d expected=none", cur_req, cyc);
            end else begin
                int    e;
                string t;
                e = exp_cyc.pop_front();
                t = exp_tag.pop_front();
                if (e != cyc) begin
                    n_fail++;
                    $display("FAIL %s irq cycle actual=%0d expected=%0d", t, cyc, e);
                end
            end
        end
    end

    task automatic reg_write(logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic strobe_start();
        @(negedge clk);
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    task automatic strobe_stop();
        @(negedge clk);
        xfer_stop = 1'b1;
        @(negedge clk);
        xfer_stop = 1'b0;
    endtask

    // one clock-pin pulse; the expected irq lands three edges after the rise
    task automatic edge_pulse(bit expect_irq);
        @(negedge clk);
        scl_in = 1'b1;
        if (expect_irq) begin
            exp_cyc.push_back(cyc + 3);
            exp_tag.push_back(cur_req);
        end
        repeat (4) @(negedge clk);
        scl_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulses(int n, int irq_on);
        for (int i = 1; i <= n; i++) edge_pulse(i == irq_on);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cur_req = "R1";
        check_eq("R1", "rdata", int'(bus_rdata), 0);
        check_eq("R1", "irq", int'(irq), 0);
        check_eq("R1", "drive_low", int'(scl_drive_low), 1);

        // R11 spare bits and read-only level bit
        cur_req = "R11";
        reg_write(8'hF0);
        check_eq("R11", "rdata spare", int'(bus_rdata), 8'hB0);
        scl_in = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R11", "rdata level", int'(bus_rdata), 8'hF0);
        scl_in = 1'b0;
        repeat (3) @(negedge clk);

        // R10 idle level selection
        cur_req = "R10";
        reg_write(8'h08);
        check_eq("R10", "idle clc1 drive_low", int'(scl_drive_low), 0);
        reg_write(8'h00);
        check_eq("R10", "idle clc0 drive_low", int'(scl_drive_low), 1);

        // R4 mode 00: interrupt on 8th edge, no hold
        cur_req = "R4";
        strobe_start();
        check_eq("R10", "in transfer drive_low", int'(scl_drive_low), 0);
        pulses(8, 8);
        check_eq("R4", "no hold drive_low", int'(scl_drive_low), 0);
        edge_pulse(1'b0);
        strobe_stop();
        check_eq("R10", "after stop drive_low", int'(scl_drive_low), 1);

        // R5 reserved mode
        cur_req = "R5";
        reg_write(8'h01);
        strobe_start();
        pulses(10, 0);
        check_eq("R5", "no hold drive_low", int'(scl_drive_low), 0);
        strobe_stop();

        // R2 mode 10 hold, R8 frozen count, R6 release
        cur_req = "R2";
        reg_write(8'h02);
        strobe_start();
        pulses(8, 8);
        check_eq("R2", "hold drive_low", int'(scl_drive_low), 1);
        cur_req = "R8";
        pulses(2, 0);
        check_eq("R8", "still held drive_low", int'(scl_drive_low), 1);
        cur_req = "R6";
        reg_write(8'h06);
        check_eq("R6", "wrel set", int'(bus_rdata[2]), 1);
        check_eq("R6", "held before release", int'(scl_drive_low), 1);
        @(negedge clk);
        check_eq("R6", "wrel cleared", int'(bus_rdata[2]), 0);
        check_eq("R6", "released drive_low", int'(scl_drive_low), 0);
        cur_req = "R8";
        reg_write(8'h03);
        edge_pulse(1'b1);
        check_eq("R8", "9th edge hold", int'(scl_drive_low), 1);
        reg_write(8'h07);
        @(negedge clk);
        check_eq("R6", "second release", int'(scl_drive_low), 0);
        strobe_stop();

        // R3 mode 11: interrupt on 9th edge
        cur_req = "R3";
        reg_write(8'h03);
        strobe_start();
        pulses(8, 0);
        check_eq("R3", "no hold at 8th", int'(scl_drive_low), 0);
        edge_pulse(1'b1);
        check_eq("R3", "hold at 9th", int'(scl_drive_low), 1);
        reg_write(8'h07);
        @(negedge clk);
        check_eq("R3", "released", int'(scl_drive_low), 0);
        strobe_stop();

        // R7 release with no hold
        cur_req = "R7";
        reg_write(8'h04);
        check_eq("R7", "wrel idle", int'(bus_rdata[2]), 0);
        check_eq("R7", "drive_low idle", int'(scl_drive_low), 1);
        strobe_start();
        reg_write(8'h04);
        check_eq("R7", "wrel shifting", int'(bus_rdata[2]), 0);
        check_eq("R7", "drive_low shifting", int'(scl_drive_low), 0);
        strobe_stop();

        // R9 restart clears the count
        cur_req = "R9";
        reg_write(8'h00);
        strobe_start();
        pulses(5, 0);
        strobe_start();
        pulses(8, 8);
        strobe_stop();

        repeat (10) @(negedge clk);
        check_eq("R9", "pending irqs", exp_cyc.size(), 0);
        finish_run();
    end
endmodule